// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an external 8-bit successive-approximation converter. Software writes one 8-bit control word that holds a channel number, a conversion mode, a clock divider choice and a busy flag. Setting the busy flag starts a conversion. The block then derives a slower converter clock from the system clock. Every conversion follows the same fixed timeline of converter clocks: a reset step, a sampling window, one decision per result bit from MSB to LSB, and a final step that loads the result.

The analog parts are outside the block: the input multiplexer, the DAC array and the comparator. The sequencer drives the positive and negative channel selects, the sample switch and the trial DAC code. It reads back a single comparator bit. A single-shot conversion clears the busy flag when it finishes. A continuous conversion keeps busy set and repeats. Between two continuous conversions, the converter is deselected for one converter clock. The result register changes only in one cycle, with all bits at once. A halt input aborts the conversion in progress. The conversion then starts over from its reset step when halt is released.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, ctrlReg and result read 0, and adcActive, sampleOn and adcClk are low.
- R2: ctrlReg fields: [7:5] channel, [4:3] mode, [2:1] divider select, [0] busy. A write while busy is 0 loads all eight bits, and they read back unchanged.
- R3: Divider select 00/01/10/11 makes one converter clock last 2/4/6/12 system clocks. adcClk is high for the first half of each converter clock, and it stays low while busy is 0 or halt is high.
- R4: Counted from the write that sets busy, a conversion lasts 17 converter clocks: 1 reset, 7 sample, 8 decision, 1 load. sampleOn is high for exactly the 7 sample converter clocks.
- R5: In decision step k (k = 0..7), dacCode equals the bits already decided with bit 7-k set to 1. At the end of that step, bit 7-k keeps the value of cmpIn. The loaded result therefore equals the input level, clamped to 0..255.
- R6: Mode 00 (single-ended, once) and mode 10 (differential, once) clear busy in the cycle that loads the result. After that, adcActive stays low.
- R7: Mode 01 (single-ended, repeat) and mode 11 (differential, repeat) keep busy at 1. After each load, adcActive is low for exactly one converter clock, and then the next conversion starts from its reset step.
- R8: While busy is 1, a write with bit 0 set changes nothing in ctrlReg and does not restart the conversion.
- R9: While busy is 1, a write with bit 0 clear changes only the busy bit to 0. It aborts the conversion, and result keeps its old value. The next write with bit 0 set loads new fields and starts in that one write.
- R10: result changes only in the cycle after a load step ends, and all 8 bits change together.
- R11: posSel equals the channel field. In modes 10 and 11, diffEn is 1 and negSel is the channel with bit 0 inverted. In modes 00 and 01, diffEn and negSel are 0.
- R12: While haltReq is high, adcActive, sampleOn and adcClk are low and busy is kept. After release, the conversion restarts from its reset step and takes the full 17 converter clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 8 | Control word write value |
| haltReq | input | 1 | Halt/idle request; aborts and holds the converter |
| cmpIn | input | 1 | Comparator decision, 1 when input is at or above dacCode |
| ctrlReg | output | 8 | Control word readback |
| result | output | 8 | Last completed conversion result |
| adcClk | output | 1 | Divided converter clock |
| adcActive | output | 1 | Converter powered and selected |
| sampleOn | output | 1 | Sample switch closed |
| dacCode | output | 8 | Trial code for the DAC array |
| posSel | output | 3 | Positive input channel select |
| negSel | output | 3 | Negative input channel select |
| diffEn | output | 1 | Differential input selected |

## Verification
A wrong phase count shows up within one converter clock as a sampleOn or adcActive edge in the wrong cycle, and over a whole conversion as a changed busy duration. A wrong decision bit or a wrong trial code shows up on dacCode in the very step where it happens, and later as a wrong result. A fault in the divider counter moves adcClk edges inside the first converter clock. A lost write lock is visible on ctrlReg in the cycle after the write. The bench compares every output with a behavioural model on every clock. It also measures durations and checks final values against the analog levels it supplies.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  localparam int CTRL_W = 8;
  localparam int RES_W = 8;
  localparam int CH_W = 3;
  localparam int SAMPLE_CYC = 7;
  localparam int IDX_W = $clog2(RES_W);
  localparam int CH_HI = 7;
  localparam int CH_LO = 5;
  localparam int MD_HI = 4;
  localparam int MD_LO = 3;
  localparam int PS_HI = 2;
  localparam int PS_LO = 1;
  localparam int BUSY_BIT = 0;
  localparam int PH_RST = 0;
  localparam int PH_DEC0 = SAMPLE_CYC + 1;
  localparam int PH_LOAD = SAMPLE_CYC + RES_W + 1;
  localparam int PH_GAP = PH_LOAD + 1;
  localparam int PH_W = $clog2(PH_GAP + 1);
  localparam int DIV_W = 4;

  typedef enum logic [1:0] {
    MODE_SE_ONE = 2'b00,
    MODE_SE_RUN = 2'b01,
    MODE_DF_ONE = 2'b10,
    MODE_DF_RUN = 2'b11
  } convMode_e;

  typedef struct packed {
    logic             clrAcc;
    logic             trialEn;
    logic             decide;
    logic [IDX_W-1:0] bitIdx;
    logic             load;
  } dpStrobe_t;
endpackage

// File: rtl/sar_conv_presc.sv
module sar_conv_presc
  import sar_conv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick,
  output logic       convClk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divVal;

  always_comb begin
    unique case (sel)
      2'b00:   divVal = DIV_W'(2);
      2'b01:   divVal = DIV_W'(4);
      2'b10:   divVal = DIV_W'(6);
      default: divVal = DIV_W'(12);
    endcase
  end

  assign tick    = run && (cnt == divVal - DIV_W'(1));
  assign convClk = run && (cnt < (divVal >> 1));

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (restart || !run || tick) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end

  // R3
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              haltReq,
  input  logic              tick,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              run,
  output logic              restart,
  output logic              active,
  output logic              sampleOn,
  output logic [CH_W-1:0]   posSel,
  output logic [CH_W-1:0]   negSel,
  output logic              diffEn,
  output logic [1:0]        prescSel,
  output dpStrobe_t         st
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   bitIdxW;
  logic busy, contMode, stopWr, loadWr, lastTick;
  logic inGap, inSample, inDecide;
  convMode_e mode;

  assign mode     = convMode_e'(ctrlQ[MD_HI:MD_LO]);
  assign busy     = ctrlQ[BUSY_BIT];
  assign contMode = (mode == MODE_SE_RUN) || (mode == MODE_DF_RUN);
  assign diffEn   = (mode == MODE_DF_ONE) || (mode == MODE_DF_RUN);
  assign posSel   = ctrlQ[CH_HI:CH_LO];
  assign negSel   = diffEn ? (posSel ^ CH_W'(1)) : '0;
  assign prescSel = ctrlQ[PS_HI:PS_LO];
  assign ctrlReg  = ctrlQ;

  assign stopWr   = wrEn && busy && !wrData[BUSY_BIT];
  assign loadWr   = wrEn && !busy;
  assign inGap    = (phase == PH_W'(PH_GAP));
  assign inSample = (phase > PH_W'(PH_RST)) && (phase < PH_W'(PH_DEC0));
  assign inDecide = (phase >= PH_W'(PH_DEC0)) && (phase < PH_W'(PH_LOAD));
  assign lastTick = tick && (phase == PH_W'(PH_LOAD));

  assign run      = busy && !haltReq;
  assign restart  = stopWr;
  assign active   = run && !inGap;
  assign sampleOn = active && inSample;

  assign bitIdxW    = PH_W'(PH_LOAD - 1) - phase;
  assign st.clrAcc  = tick && (phase == PH_W'(PH_RST));
  assign st.trialEn = inDecide;
  assign st.decide  = tick && inDecide;
  assign st.bitIdx  = bitIdxW[IDX_W-1:0];
  assign st.load    = lastTick && !stopWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      phase <= '0;
    end else begin
      if (loadWr) ctrlQ <= wrData;
      else if (stopWr) ctrlQ[BUSY_BIT] <= 1'b0;
      else if (lastTick && !contMode) ctrlQ[BUSY_BIT] <= 1'b0;

      if (!busy || haltReq || stopWr) phase <= '0;
      else if (tick) begin
        if (lastTick) phase <= contMode ? PH_W'(PH_GAP) : PH_W'(PH_RST);
        else if (inGap) phase <= PH_W'(PH_RST);
        else phase <= phase + PH_W'(1);
      end
    end
  end

  // R8
  field_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> (ctrlQ[CTRL_W-1:1] == $past(ctrlQ[CTRL_W-1:1])));
  // R6
  single_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastTick && !contMode) |=> !ctrlQ[BUSY_BIT]);
  // R7
  cont_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastTick && contMode && !stopWr) |=> (ctrlQ[BUSY_BIT] && !active));
  // R4
  sample_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleOn) |-> ($past(phase) == PH_W'(PH_RST)));
endmodule

// File: rtl/sar_conv_dp.sv
module sar_conv_dp
  import sar_conv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        st,
  input  logic             cmpIn,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] trialMask;

  assign trialMask = st.trialEn ? (RES_W'(1) << st.bitIdx) : '0;
  assign dacCode   = acc | trialMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (st.clrAcc) acc <= '0;
      else if (st.decide) acc[st.bitIdx] <= cmpIn;
      if (st.load) result <= acc;
    end
  end

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (result != $past(result)) |-> $past(st.load));
  // R5
  msb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.trialEn) |-> (dacCode == (RES_W'(1) << (RES_W - 1))));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              haltReq,
  input  logic              cmpIn,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [RES_W-1:0]  result,
  output logic              adcClk,
  output logic              adcActive,
  output logic              sampleOn,
  output logic [RES_W-1:0]  dacCode,
  output logic [CH_W-1:0]   posSel,
  output logic [CH_W-1:0]   negSel,
  output logic              diffEn
);
  logic       run, restart, tick;
  logic [1:0] prescSel;
  dpStrobe_t  st;

  sar_conv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .haltReq(haltReq),
    .tick(tick), .ctrlReg(ctrlReg), .run(run), .restart(restart),
    .active(adcActive), .sampleOn(sampleOn), .posSel(posSel), .negSel(negSel),
    .diffEn(diffEn), .prescSel(prescSel), .st(st)
  );

  sar_conv_presc u_presc (
    .clk(clk), .rstN(rstN), .run(run), .restart(restart), .sel(prescSel),
    .tick(tick), .convClk(adcClk)
  );

  sar_conv_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cmpIn(cmpIn),
    .dacCode(dacCode), .result(result)
  );
endmodule

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       haltReq = 1'b0;
  logic       cmpIn;
  logic [7:0] ctrlReg, result, dacCode;
  logic       adcClk, adcActive, sampleOn, diffEn;
  logic [2:0] posSel, negSel;

  int chanV [8];
  int posV, negV, vinNow;
  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // model state
  int mCtrl = 0, mPhase = 0, mCnt = 0, mAcc = 0, mResult = 0;

  always #2.5 clk = ~clk;

  sar_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .haltReq(haltReq),
    .cmpIn(cmpIn), .ctrlReg(ctrlReg), .result(result), .adcClk(adcClk),
    .adcActive(adcActive), .sampleOn(sampleOn), .dacCode(dacCode),
    .posSel(posSel), .negSel(negSel), .diffEn(diffEn)
  );

  // analog front end model
  assign posV   = chanV[posSel];
  assign negV   = chanV[negSel];
  assign vinNow = diffEn ? ((posV > negV) ? posV - negV : 0) : posV;
  assign cmpIn  = (vinNow >= int'(dacCode));

  function automatic int divOf(input int s);
    case (s)
      0: return 2;
      1: return 4;
      2: return 6;
      default: return 12;
    endcase
  endfunction

  function automatic int mVin();
    int p, n;
    p = (mCtrl >> 5) & 7;
    if ((mCtrl >> 4) & 1) begin
      n = p ^ 1;
      return (chanV[p] > chanV[n]) ? chanV[p] - chanV[n] : 0;
    end
    return chanV[p];
  endfunction

  function automatic int mTrial();
    if (mPhase >= 8 && mPhase <= 15) return mAcc | (1 << (15 - mPhase));
    return mAcc;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mPhase = 0; mCnt = 0; mAcc = 0; mResult = 0;
    end else begin
      bit busyB, runB, tickB, stopB, lastB, contB;
      int tr;
      busyB = mCtrl[0];
      runB  = busyB && !haltReq;
      tickB = runB && (mCnt == divOf((mCtrl >> 1) & 3) - 1);
      stopB = wrEn && busyB && !wrData[0];
      lastB = tickB && (mPhase == 16);
      contB = mCtrl[3];
      tr    = mTrial();
      if (lastB && !stopB) mResult = mAcc;
      if (tickB && mPhase == 0) mAcc = 0;
      else if (tickB && mPhase >= 8 && mPhase <= 15 && mVin() >= tr) mAcc = tr;
      if (!runB || stopB || tickB) mCnt = 0; else mCnt++;
      if (!busyB || haltReq || stopB) mPhase = 0;
      else if (tickB) begin
        if (lastB) mPhase = contB ? 17 : 0;
        else if (mPhase == 17) mPhase = 0;
        else mPhase++;
      end
      if (wrEn && !busyB) mCtrl = int'(wrData);
      else if (stopB) mCtrl = mCtrl & 'hFE;
      else if (lastB && !contB) mCtrl = mCtrl & 'hFE;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      bit eRun, eAct;
      int p, d;
      eRun = mCtrl[0] && !haltReq;
      eAct = eRun && mPhase != 17;
      p = (mCtrl >> 5) & 7;
      d = (mCtrl >> 4) & 1;
      chk("R2 ctrlReg", ctrlReg, mCtrl);
      chk("R10 result", result, mResult);
      chk("R4 sampleOn", sampleOn, eAct && mPhase >= 1 && mPhase <= 7);
      chk("R7 adcActive", adcActive, eAct);
      chk("R3 adcClk", adcClk, eRun && (mCnt < divOf((mCtrl >> 1) & 3) / 2));
      chk("R5 dacCode", dacCode, mTrial());
      chk("R11 posSel", posSel, p);
      chk("R11 negSel", negSel, d ? (p ^ 1) : 0);
      chk("R11 diffEn", diffEn, d);
    end
  end

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // counts negedges with busy high, from the current one on
  task automatic busyLen(output int cyc, output int smp);
    cyc = 0; smp = 0;
    while (ctrlReg[0] && cyc < 5000) begin
      cyc++;
      if (sampleOn) smp++;
      @(negedge clk);
    end
  endtask

  task automatic waitResult(input int v, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      if (int'(result) == v) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int cyc, smp, gap, prevRes;
    bit ok;
    chanV[0] = 1;   chanV[1] = 60;  chanV[2] = 90;  chanV[3] = 165;
    chanV[4] = 33;  chanV[5] = 255; chanV[6] = 200; chanV[7] = 57;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrlReg", ctrlReg, 0);
    chk("R1 result", result, 0);
    chk("R1 idle", {adcActive, sampleOn, adcClk}, 0);

    // R2 readback with busy clear; R3 clock idle
    writeReg(8'hB6);
    chk("R2 readback", ctrlReg, 'hB6);
    repeat (3) @(negedge clk);
    chk("R3 adcClk idle", adcClk, 0);

    // R4/R5 single-ended single, divide by 2, channel 3
    writeReg(8'h61);
    busyLen(cyc, smp);
    chk("R4 busy length", cyc, 17 * 2);
    chk("R4 sample length", smp, 7 * 2);
    chk("R5 result", result, 165);
    chk("R6 inactive after", adcActive, 0);

    // R11 differential single, divide by 12, channel 6 vs 7
    writeReg(8'hD7);
    chk("R11 negSel", negSel, 7);
    chk("R11 diffEn", diffEn, 1);
    busyLen(cyc, smp);
    chk("R3 busy length div12", cyc, 17 * 12);
    chk("R11 diff result", result, 143);

    // R7 continuous on channel 1, divide by 4
    writeReg(8'h2B);
    waitResult(60, 400, ok);
    chk("R7 first result", ok, 1);
    gap = 0;
    while (!adcActive && gap < 100) begin gap++; @(negedge clk); end
    chk("R7 gap length", gap, 4);
    chk("R7 busy kept", ctrlReg[0], 1);
    // R8 write with busy set while busy is ignored
    writeReg(8'hFF);
    chk("R8 fields locked", ctrlReg, 'h2B);
    chanV[1] = 129;
    waitResult(129, 400, ok);
    chk("R7 repeated result", ok, 1);

    // R9 stop then restart with new fields in one write
    repeat (10) @(negedge clk);
    writeReg(8'h00);
    chk("R9 stop busy only", ctrlReg, 'h2A);
    prevRes = result;
    repeat (100) @(negedge clk);
    chk("R9 result kept", result, prevRes);
    chk("R9 inactive", adcActive, 0);
    writeReg(8'h53);
    chk("R9 load and start", ctrlReg, 'h53);
    busyLen(cyc, smp);
    chk("R9 busy length", cyc, 17 * 4);
    chk("R11 diff clamp", result, 0);

    // R12 halt aborts and restarts
    writeReg(8'hA1);
    repeat (10) @(negedge clk);
    haltReq = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 19) begin
        chk("R12 halted outputs", {adcActive, sampleOn, adcClk}, 0);
        chk("R12 busy kept", ctrlReg[0], 1);
      end
    end
    haltReq = 1'b0;
    busyLen(cyc, smp);
    chk("R12 full restart", cyc, 17 * 2);
    chk("R12 result", result, 255);

    // R3 divide by 6
    writeReg(8'h05);
    busyLen(cyc, smp);
    chk("R3 busy length div6", cyc, 17 * 6);
    chk("R5 small result", result, 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule